// File: doc/BRIEF.md
# Clock Fault Interrupt Latch and Mask Unit

This block turns single-cycle fault pulses into sticky status bits and drives one active-low interrupt request line. It receives strobes for six kinds of clock fault, one for a clock that was still missing when the pre-power-up wait expired, and one for a watchdog fault in the control state machine. The fault detectors themselves and the serial control bus sit outside the block.

The status bits fall into two groups. Each group has its own mask register. A host reaches both groups through a small register port with a two-bit address. Writing a 1 to a status bit clears that bit. A pulse on any clock-fault input also sets a shared summary bit. The pre-power-up fault is the exception: it lives only in the second group and never sets the summary bit. The interrupt line goes low whenever a set status bit has its mask bit at 0.

Top module: `clkerr_irq_ctrl`

## Requirements
- R1: On synchronous reset, all status bits go to 0 and `irq_n` goes to 1. Mask group A resets to 6'b110111 (only the summary bit is enabled). Mask group B resets to 3'b100 (the watchdog is enabled and the pre-power-up fault is masked). Read data resets to 0.
- R2: While `det_en`=1, a pulse on `evt_clk[i]` sets status A bit i. The bits are: 0 frame rate invalid, 1 frame rate changed, 2 frame to bit clock ratio changed, 3 summary clock fault, 4 internal PLL clock fault, 5 frame out of sync. A set bit stays set after the pulse ends.
- R3: Any pulse on `evt_clk` while `det_en`=1 also sets status A bit 3 at the same clock edge.
- R4: A pulse on `evt_pre` while `det_en`=1 sets status B bit 2. It leaves status A bit 3 unchanged.
- R5: A pulse on `evt_wdog` sets status B bit 0, whatever the value of `det_en`.
- R6: While `det_en`=0, pulses on `evt_clk` and `evt_pre` change no status bit.
- R7: A write to address 0 clears every status A bit whose write-data bit is 1. A write to address 2 does the same for status B. Bits written with 0 keep their value.
- R8: If a fault pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R9: `irq_n` is registered. One cycle after (status & ~mask) is nonzero in either group, `irq_n` is 0. Otherwise it is 1. A mask bit of 1 suppresses its status bit.
- R10: A write to address 1 loads mask A. A write to address 3 loads mask B. `reg_rdata` shows, one cycle after the address is presented, the register at that address (0 status A, 1 mask A, 2 status B, 3 mask B). Bits with no function read 0 and cannot be written; these are B bit 1 and every bit above each group's width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Enables latching of clock-fault pulses |
| evt_clk | input | 6 | Clock fault pulses, in status A bit positions |
| evt_pre | input | 1 | Pre-power-up clock fault pulse |
| evt_wdog | input | 1 | Watchdog fault pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request, registered |

## Verification
A fault pulse and a write-one-to-clear can land on the same status bit in the same cycle. The bench provokes this in a directed case and also lets it occur often in random traffic, where events and clear writes are drawn independently. The bench model decides that the set wins, then judges the result at the read port and at `irq_n` on the following cycles.

// File: rtl/clkerr_pkg.sv
package clkerr_pkg;
  localparam int DW     = 8;
  localparam int AW     = 2;
  localparam int GA_W   = 6;
  localparam int GB_W   = 3;
  localparam int SUM_BIT  = 3;
  localparam int WDOG_BIT = 0;
  localparam int PRE_BIT  = 2;
  localparam logic [AW-1:0] A_STAT = 2'd0;
  localparam logic [AW-1:0] A_MASK = 2'd1;
  localparam logic [AW-1:0] B_STAT = 2'd2;
  localparam logic [AW-1:0] B_MASK = 2'd3;
  localparam logic [GA_W-1:0] GA_IMPL = 6'b111111;
  localparam logic [GB_W-1:0] GB_IMPL = 3'b101;
  localparam logic [GA_W-1:0] GA_MRST = 6'b110111;
  localparam logic [GB_W-1:0] GB_MRST = 3'b100;
endpackage

// File: rtl/status_bank.sv
module status_bank #(
  parameter int W = 6,
  parameter logic [W-1:0] IMPL = '1,
  parameter logic [W-1:0] MRST = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] clr_v;

  assign clr_v = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      mask_o   <= MRST & IMPL;
    end else begin
      // set has priority over a concurrent clear
      status_o <= ((status_o & ~clr_v) | set_i) & IMPL;
      if (mask_we) mask_o <= wdata & IMPL;
    end
  end

  assign pend_o = status_o & ~mask_o;
endmodule

// File: rtl/irq_drive.sv
module irq_drive #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  output logic         irq_n
);
  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(|pend);
  end
endmodule

// File: rtl/clkerr_irq_ctrl.sv
module clkerr_irq_ctrl
  import clkerr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          det_en,
  input  logic [GA_W-1:0] evt_clk,
  input  logic          evt_pre,
  input  logic          evt_wdog,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_n
);
  logic [GA_W-1:0] set_a, st_a, mk_a, pend_a;
  logic [GB_W-1:0] set_b, st_b, mk_b, pend_b;

  always_comb begin
    set_a = '0;
    set_b = '0;
    if (det_en) begin
      set_a = evt_clk;
      if (|evt_clk) set_a[SUM_BIT] = 1'b1;
      set_b[PRE_BIT] = evt_pre;
    end
    set_b[WDOG_BIT] = evt_wdog;
  end

  status_bank #(.W(GA_W), .IMPL(GA_IMPL), .MRST(GA_MRST)) u_bank_a (
    .clk(clk), .rst(rst), .set_i(set_a),
    .clr_we(reg_wr && reg_addr == A_STAT),
    .mask_we(reg_wr && reg_addr == A_MASK),
    .wdata(reg_wdata[GA_W-1:0]),
    .status_o(st_a), .mask_o(mk_a), .pend_o(pend_a)
  );

  status_bank #(.W(GB_W), .IMPL(GB_IMPL), .MRST(GB_MRST)) u_bank_b (
    .clk(clk), .rst(rst), .set_i(set_b),
    .clr_we(reg_wr && reg_addr == B_STAT),
    .mask_we(reg_wr && reg_addr == B_MASK),
    .wdata(reg_wdata[GB_W-1:0]),
    .status_o(st_b), .mask_o(mk_b), .pend_o(pend_b)
  );

  irq_drive #(.N(GA_W + GB_W)) u_irq (
    .clk(clk), .rst(rst), .pend({pend_b, pend_a}), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        A_STAT:  reg_rdata <= DW'(st_a);
        A_MASK:  reg_rdata <= DW'(mk_a);
        B_STAT:  reg_rdata <= DW'(st_b);
        default: reg_rdata <= DW'(mk_b);
      endcase
    end
  end
endmodule

// File: rtl/clkerr_irq_chk.sv
module clkerr_irq_chk
  import clkerr_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            det_en,
  input logic [GA_W-1:0] evt_clk,
  input logic            evt_pre,
  input logic            evt_wdog,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic            irq_n,
  input logic [GA_W-1:0] st_a,
  input logic [GA_W-1:0] mk_a,
  input logic [GB_W-1:0] st_b,
  input logic [GB_W-1:0] mk_b
);
  // R3
  sum_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (det_en && |evt_clk) |=> st_a[SUM_BIT]);
  // R4
  pre_no_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (det_en && evt_pre && evt_clk == '0 && !st_a[SUM_BIT] &&
     !(reg_wr && reg_addr == A_STAT)) |=> (st_b[PRE_BIT] && !st_a[SUM_BIT]));
  // R5
  wdog_latch_chk: assert property (@(posedge clk) disable iff (rst)
    evt_wdog |=> st_b[WDOG_BIT]);
  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (st_a[0] && !(reg_wr && reg_addr == A_STAT && reg_wdata[0])) |=> st_a[0]);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (det_en && evt_clk[0] && reg_wr && reg_addr == A_STAT && reg_wdata[0]) |=> st_a[0]);
  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    (|(st_a & ~mk_a) || |(st_b & ~mk_b)) |=> !irq_n);
  // R9
  irq_high_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(st_a & ~mk_a) || |(st_b & ~mk_b)) |=> irq_n);
endmodule

bind clkerr_irq_ctrl clkerr_irq_chk u_chk (
  .clk(clk), .rst(rst), .det_en(det_en), .evt_clk(evt_clk), .evt_pre(evt_pre),
  .evt_wdog(evt_wdog), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_n(irq_n), .st_a(st_a), .mk_a(mk_a), .st_b(st_b), .mk_b(mk_b)
);

// File: tb/clkerr_irq_ctrl_tb.sv
module clkerr_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       det_en = 1'b1;
  logic [5:0] evt_clk = '0;
  logic       evt_pre = 1'b0, evt_wdog = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int n_chk = 0, n_bad = 0;
  logic [5:0] sa, ma;
  logic [2:0] sb, mb;
  logic [7:0] exp_rd;
  logic       exp_irq;
  string      tag;

  always #10 clk = ~clk;

  clkerr_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .det_en(det_en), .evt_clk(evt_clk), .evt_pre(evt_pre),
    .evt_wdog(evt_wdog), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  function automatic logic [7:0] rd_model(input logic [1:0] a);
    case (a)
      2'd0: return {2'b0, sa};
      2'd1: return {2'b0, ma};
      2'd2: return {5'b0, sb};
      default: return {5'b0, mb};
    endcase
  endfunction

  task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  // one cycle: compare outputs, drive inputs, advance the model
  task automatic cyc(input logic [5:0] ev, input logic pre, input logic wd,
                     input logic det, input logic wr, input logic [1:0] ad,
                     input logic [7:0] dat);
    logic [5:0] set_a, clr_a;
    logic [2:0] set_b, clr_b;
    @(negedge clk);
    check("R9 irq_n", {7'b0, irq_n}, {7'b0, exp_irq});
    check({tag, " rdata"}, reg_rdata, exp_rd);
    evt_clk = ev; evt_pre = pre; evt_wdog = wd; det_en = det;
    reg_wr = wr; reg_addr = ad; reg_wdata = dat;
    exp_irq = !(|(sa & ~ma) || |(sb & ~mb));
    exp_rd  = rd_model(ad);
    set_a = det ? (ev | ((|ev) ? 6'b001000 : 6'b0)) : 6'b0;
    set_b = {det & pre, 1'b0, wd};
    clr_a = (wr && ad == 2'd0) ? dat[5:0] : 6'b0;
    clr_b = (wr && ad == 2'd2) ? (dat[2:0] & 3'b101) : 3'b0;
    sa = (sa & ~clr_a) | set_a;
    sb = (sb & ~clr_b) | set_b;
    if (wr && ad == 2'd1) ma = dat[5:0];
    if (wr && ad == 2'd3) mb = dat[2:0] & 3'b101;
  endtask

  task automatic rd(input logic [1:0] ad);
    cyc(6'b0, 1'b0, 1'b0, 1'b1, 1'b0, ad, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    sa = '0; sb = '0; ma = 6'b110111; mb = 3'b100;
    exp_rd = 8'h00; exp_irq = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset values
    tag = "R1";
    rd(2'd1); rd(2'd3); rd(2'd0); rd(2'd2); rd(2'd0);
    // R2 single event then hold
    tag = "R2";
    cyc(6'b000001, 0, 0, 1, 0, 2'd0, 0); rd(2'd0); rd(2'd0); rd(2'd0);
    // R7 clear
    tag = "R7";
    cyc(0, 0, 0, 1, 1, 2'd0, 8'h09); rd(2'd0); rd(2'd0);
    // R3 PLL fault sets summary
    tag = "R3";
    cyc(6'b010000, 0, 0, 1, 0, 2'd0, 0); rd(2'd0); rd(2'd0);
    cyc(0, 0, 0, 1, 1, 2'd0, 8'h3F); rd(2'd0);
    // R4 pre-power-up only in group B
    tag = "R4";
    cyc(0, 1, 0, 1, 0, 2'd2, 0); rd(2'd2); rd(2'd0); rd(2'd0);
    cyc(0, 0, 0, 1, 1, 2'd2, 8'h04); rd(2'd2);
    // R5 watchdog latches with detection off
    tag = "R5";
    cyc(0, 0, 1, 0, 0, 2'd2, 0); rd(2'd2); rd(2'd2); rd(2'd2);
    cyc(0, 0, 0, 1, 1, 2'd2, 8'h01); rd(2'd2); rd(2'd2);
    // R6 detection disabled
    tag = "R6";
    cyc(6'b111111, 1, 0, 0, 0, 2'd0, 0); rd(2'd0); rd(2'd2); rd(2'd2);
    // R8 event and clear together
    tag = "R8";
    cyc(6'b100000, 0, 0, 1, 0, 2'd0, 0);
    cyc(6'b100000, 0, 0, 1, 1, 2'd0, 8'h28); rd(2'd0); rd(2'd0);
    cyc(0, 0, 0, 1, 1, 2'd0, 8'hFF); rd(2'd0);
    // R10 mask writes, reserved bits
    tag = "R10";
    cyc(0, 0, 0, 1, 1, 2'd3, 8'hFF); rd(2'd3); rd(2'd3);
    cyc(0, 0, 0, 1, 1, 2'd1, 8'hC0); rd(2'd1); rd(2'd1);
    cyc(6'b000100, 0, 0, 1, 0, 2'd0, 0); rd(2'd0); rd(2'd0);
    cyc(0, 0, 0, 1, 1, 2'd1, 8'h3F); rd(2'd0); rd(2'd0);
    // R9 random traffic
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] ev;
      logic wr;
      ev  = ($urandom_range(0, 5) == 0) ? 6'($urandom) : 6'b0;
      wr  = ($urandom_range(0, 3) == 0);
      cyc(ev, $urandom_range(0, 9) == 0, $urandom_range(0, 15) == 0,
          $urandom_range(0, 7) != 0, wr, 2'($urandom), 8'($urandom));
    end
    rd(2'd0); rd(2'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule